// File: doc/BRIEF.md
# Dual-Clock Decade Up/Down Counter

This block is a four-bit decimal counter with no direction pin. The count direction comes from which of two count strobes makes a rising transition. One strobe counts up and the other counts down. A strobe edge is honoured only while the opposite strobe rests high. An active-high clear forces the value to zero, and an active-low load copies a four-bit preset word. Both act as levels and show on the count output at once, without waiting for a strobe.

Two active-low terminal outputs support chaining stages. The up-side output drops while the counter shows nine and the up strobe is low. The down-side output drops while the counter shows zero and the down strobe is low. A next stage can therefore treat them as its own up and down strobes. The whole block runs from one system clock. The strobes are resynchronised, and their rising edges are found by comparing the synchronised level with the level one system cycle earlier.

Top module: `dec_updown_ctr`

## Requirements
- R1: A rising up strobe while the down strobe is high adds one to the count (4-bit binary, bit 0 least significant); 9 steps to 0.
- R2: A rising down strobe while the up strobe is high subtracts one; 0 steps to 9.
- R3: While clear_i is 1 the count output reads 0 in the same cycle, overriding load and both strobes, and stays 0 after clear falls.
- R4: While load_n_i is 0 and clear_i is 0 the count output reads preset_i in the same cycle, whatever the strobes do; the value is kept after load_n_i rises.
- R5: Counting up from a code above 9 follows 10→11→6, 12→13→4, 14→15→2.
- R6: Counting down from a code above 9 subtracts one per step (15 down to 10, then 9).
- R7: carry_n_o is 0 while count bits 0 and 3 are both 1 and the up strobe is low, and 1 otherwise.
- R8: borrow_n_o is 0 while the count is 0 and the down strobe is low, and 1 otherwise.
- R9: A rising strobe is ignored while the other strobe is low, and rising edges on both strobes in the same system cycle leave the count unchanged.
- R10: After rst_n is released the count is 0 and both terminal outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| up_clk_i | input | 1 | Up strobe; its rising edge counts up |
| dn_clk_i | input | 1 | Down strobe; its rising edge counts down |
| clear_i | input | 1 | Active-high master clear |
| load_n_i | input | 1 | Active-low preset load |
| preset_i | input | 4 | Preset word |
| count_o | output | 4 | Current count |
| carry_n_o | output | 1 | Active-low terminal count, up direction |
| borrow_n_o | output | 1 | Active-low terminal count, down direction |

## Verification
The hardest states to reach are the six codes above nine. Normal counting never enters them, so every recovery path can only be reached by a load. The bench therefore presets each of the sixteen codes in turn and applies a single strobe in each direction, comparing against an independent successor table. The coincident-edge case needs both strobes lowered and then raised in the same system cycle. The ignored-edge case needs the opposite strobe held low across a whole pulse. Both are built directly by the scenario tasks.

// File: rtl/dec_ctr_pkg.sv
package dec_ctr_pkg;

  localparam int CW = 4;
  localparam logic [CW-1:0] TOP_LEGAL = 4'd9;

  typedef logic [CW-1:0] cnt_t;

  // successor when counting up, including recovery of codes 10..15
  function automatic cnt_t step_up(input cnt_t v);
    cnt_t r;
    case (v)
      4'd9:    r = 4'd0;
      4'd11:   r = 4'd6;
      4'd13:   r = 4'd4;
      4'd15:   r = 4'd2;
      default: r = v + 4'd1;
    endcase
    return r;
  endfunction

  // predecessor when counting down; codes above nine simply decrement
  function automatic cnt_t step_dn(input cnt_t v);
    cnt_t r;
    if (v == 4'd0) r = TOP_LEGAL;
    else           r = v - 4'd1;
    return r;
  endfunction

endpackage

// File: rtl/dec_ctr_sync.sv
module dec_ctr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d_i;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dec_ctr_edge.sv
module dec_ctr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);

  logic lvl;
  logic prev_q;

  dec_ctr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (strobe_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign level_o = lvl;
  assign rise_o  = lvl & ~prev_q;

endmodule

// File: rtl/dec_ctr_core.sv
module dec_ctr_core
  import dec_ctr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_lvl_i,
  input  logic up_rise_i,
  input  logic dn_lvl_i,
  input  logic dn_rise_i,
  input  logic clear_i,
  input  logic load_n_i,
  input  cnt_t preset_i,
  output cnt_t cnt_o,
  output logic carry_n_o,
  output logic borrow_n_o
);

  cnt_t cnt_q, cnt_d;
  logic up_go, dn_go;
  logic carry_n_q, carry_n_d;
  logic borrow_n_q, borrow_n_d;

  // an edge counts only while the opposite strobe rests high
  assign up_go = up_rise_i & dn_lvl_i;
  assign dn_go = dn_rise_i & up_lvl_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)               cnt_d = '0;
    else if (!load_n_i)        cnt_d = preset_i;
    else if (up_go && !dn_go)  cnt_d = step_up(cnt_q);
    else if (dn_go && !up_go)  cnt_d = step_dn(cnt_q);
  end

  always_comb begin
    carry_n_d  = ~(cnt_q[0] & cnt_q[3] & ~up_lvl_i);
    borrow_n_d = ~((cnt_q == '0) & ~dn_lvl_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      carry_n_q  <= 1'b1;
      borrow_n_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_d;
      carry_n_q  <= carry_n_d;
      borrow_n_q <= borrow_n_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign carry_n_o  = carry_n_q;
  assign borrow_n_o = borrow_n_q;

endmodule

// File: rtl/dec_updown_ctr.sv
module dec_updown_ctr
  import dec_ctr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_clk_i,
  input  logic          dn_clk_i,
  input  logic          clear_i,
  input  logic          load_n_i,
  input  logic [CW-1:0] preset_i,
  output logic [CW-1:0] count_o,
  output logic          carry_n_o,
  output logic          borrow_n_o
);

  logic up_lvl, up_rise, dn_lvl, dn_rise;
  cnt_t held;

  dec_ctr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_up_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (up_clk_i),
    .level_o  (up_lvl),
    .rise_o   (up_rise)
  );

  dec_ctr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_dn_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (dn_clk_i),
    .level_o  (dn_lvl),
    .rise_o   (dn_rise)
  );

  dec_ctr_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_lvl_i   (up_lvl),
    .up_rise_i  (up_rise),
    .dn_lvl_i   (dn_lvl),
    .dn_rise_i  (dn_rise),
    .clear_i    (clear_i),
    .load_n_i   (load_n_i),
    .preset_i   (preset_i),
    .cnt_o      (held),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

  // clear and load are levels that override the visible value immediately
  always_comb begin
    if (clear_i)        count_o = '0;
    else if (!load_n_i) count_o = preset_i;
    else                count_o = held;
  end

endmodule

// File: rtl/dec_updown_ctr_chk.sv
module dec_updown_ctr_chk
  import dec_ctr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          clear_i,
  input logic          load_n_i,
  input logic [CW-1:0] preset_i,
  input logic [CW-1:0] count_o,
  input logic          carry_n_o,
  input logic          borrow_n_o
);

  AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (clear_i || !load_n_i || count_o == '0)); // R3

  AST_LOAD_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_n_i) |=> (clear_i || !load_n_i || count_o == $past(preset_i))); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_n_i) |=> (clear_i || !load_n_i || count_o == $past(count_o) ||
      count_o == step_up($past(count_o)) || count_o == step_dn($past(count_o)))); // R1

  AST_LEGAL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_n_i && count_o <= TOP_LEGAL) |=>
      (clear_i || !load_n_i || count_o <= TOP_LEGAL)); // R5

  AST_TC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> borrow_n_o); // R7

endmodule

bind dec_updown_ctr dec_updown_ctr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_i    (clear_i),
  .load_n_i   (load_n_i),
  .preset_i   (preset_i),
  .count_o    (count_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o)
);

// File: tb/dec_updown_ctr_test.sv
module dec_updown_ctr_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_clk, dn_clk, clear, load_n;
  logic [3:0] preset;
  logic [3:0] count;
  logic       carry_n, borrow_n;

  int n_chk = 0;
  int n_bad = 0;

  // successor tables written from the requirements
  logic [3:0] up_tab [16] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
                               4'd9, 4'd0, 4'd11, 4'd6, 4'd13, 4'd4, 4'd15, 4'd2};
  logic [3:0] dn_tab [16] = '{4'd9, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
                               4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14};

  always #4 clk = ~clk;

  dec_updown_ctr uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_clk_i   (up_clk),
    .dn_clk_i   (dn_clk),
    .clear_i    (clear),
    .load_n_i   (load_n),
    .preset_i   (preset),
    .count_o    (count),
    .carry_n_o  (carry_n),
    .borrow_n_o (borrow_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; load_n = 1'b0; cycles(2); load_n = 1'b1; cycles(2);
  endtask

  task automatic pulse_up();
    up_clk = 1'b0; cycles(5); up_clk = 1'b1; cycles(5);
  endtask

  task automatic pulse_dn();
    dn_clk = 1'b0; cycles(5); dn_clk = 1'b1; cycles(5);
  endtask

  task automatic t_reset();
    check("R10 count", count, 0);
    check("R10 carry_n", carry_n, 1);
    check("R10 borrow_n", borrow_n, 1);
  endtask

  task automatic t_up_sweep();
    for (int v = 0; v < 16; v++) begin
      do_load(4'(v));
      pulse_up();
      check(v > 9 ? "R5 up recovery" : "R1 up step", count, up_tab[v]);
    end
    do_load(4'd14); pulse_up(); pulse_up();
    check("R5 14 twice", count, 2);
  endtask

  task automatic t_dn_sweep();
    for (int v = 0; v < 16; v++) begin
      do_load(4'(v));
      pulse_dn();
      check(v > 9 ? "R6 down decrement" : "R2 down step", count, dn_tab[v]);
    end
  endtask

  task automatic t_clear();
    do_load(4'd7);
    preset = 4'd5; load_n = 1'b0; clear = 1'b1; up_clk = 1'b0; #1;
    check("R3 immediate", count, 0);
    cycles(4); up_clk = 1'b1; cycles(4);
    check("R3 over load and strobe", count, 0);
    load_n = 1'b1; clear = 1'b0; cycles(3);
    check("R3 held after clear", count, 0);
  endtask

  task automatic t_load();
    preset = 4'd3; load_n = 1'b0; #1;
    check("R4 immediate", count, 3);
    up_clk = 1'b0; cycles(4); up_clk = 1'b1; cycles(4);
    dn_clk = 1'b0; cycles(4); dn_clk = 1'b1; cycles(4);
    check("R4 during strobes", count, 3);
    load_n = 1'b1; preset = 4'd8; cycles(3);
    check("R4 retained", count, 3);
  endtask

  task automatic t_ignored();
    do_load(4'd4);
    dn_clk = 1'b0; cycles(5);
    pulse_up();
    check("R9 up ignored with down low", count, 4);
    dn_clk = 1'b1; cycles(5);
    check("R2 down release counts", count, 3);
    up_clk = 1'b0; dn_clk = 1'b0; cycles(5);
    up_clk = 1'b1; dn_clk = 1'b1; cycles(5);
    check("R9 coincident edges hold", count, 3);
  endtask

  task automatic t_terminal();
    do_load(4'd9);
    check("R7 idle carry high", carry_n, 1);
    up_clk = 1'b0; cycles(5);
    check("R7 carry low at nine", carry_n, 0);
    check("R8 borrow high at nine", borrow_n, 1);
    up_clk = 1'b1; cycles(5);
    check("R1 wrap nine to zero", count, 0);
    check("R7 carry released", carry_n, 1);
    dn_clk = 1'b0; cycles(5);
    check("R8 borrow low at zero", borrow_n, 0);
    dn_clk = 1'b1; cycles(5);
    check("R2 wrap zero to nine", count, 9);
    check("R8 borrow released", borrow_n, 1);
    do_load(4'd5); up_clk = 1'b0; cycles(5);
    check("R7 carry high at five", carry_n, 1);
    up_clk = 1'b1; cycles(5);
  endtask

  initial begin
    rst_n = 1'b0; up_clk = 1'b1; dn_clk = 1'b1;
    clear = 1'b0; load_n = 1'b1; preset = 4'd0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_up_sweep();
    t_dn_sweep();
    t_clear();
    t_load();
    t_ignored();
    t_terminal();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule